// File: doc/BRIEF.md
# Hypervisor Doorbell Message Dispatcher

This block takes processor-control message commands from a group of hardware threads and keeps one pending hypervisor-doorbell flag for each thread. Each flag drives that thread's interrupt request line. A send command carries a 64-bit operand that holds a message type and a 20-bit target tag. The block compares the tag against every thread's identifier and sets the flag of each thread that matches. A clear command decodes the same operand and drops the flag of the thread that issued it. When a thread takes the interrupt, it pulses its acknowledge line, and that pulse clears its own flag.

Commands arrive on a valid/ready handshake. Each command also carries an opcode, the index of the issuing thread and a hypervisor-state bit. A small state machine controls the flow. In state ST_IDLE, ready is high. The transition ACCEPT (valid while ready) latches the command and moves to state ST_EXEC. In ST_EXEC, the block raises the completion pulse and the fault flag, and it applies the flag update at the closing clock edge. The transition RETIRE then returns it to ST_IDLE unconditionally. A new command can therefore be taken every second cycle.

Top module: `hv_doorbell_dispatch`

## Requirements
- R1: After reset, irq_o is all zero, cmd_ready_o is 1 and done_o is 0.
- R2: A command is accepted on a clock edge where cmd_valid_i and cmd_ready_o are both high. done_o is high for exactly the next cycle, and cmd_ready_o is low in that same cycle. The resulting flag change is visible on irq_o from the cycle after the done_o pulse.
- R3: Opcode 2'b00 is a send. The message type is operand bits 31:27 (bit 0 is the LSB) and the tag is operand bits 19:0. A privileged send of type 5 sets the flag of every thread whose identifier equals the tag, with no fault.
- R4: A send of any type other than 5 completes with no fault and changes no flag.
- R5: A privileged type-5 send whose tag matches no thread completes with no fault and changes no flag.
- R6: Operand bit 26 (broadcast request) and operand bits 63:32 and 25:20 are ignored. A type-5 send with any of them set behaves as a plain directed send.
- R7: Opcode 2'b01 is a clear. A privileged type-5 clear drops only the flag of the thread given by cmd_thread_i. A clear of any other type changes nothing.
- R8: A send, clear or sync issued with cmd_hyp_i low completes with fault_o high during the done_o cycle and changes no flag. fault_o is never high outside a done_o cycle.
- R9: Opcode 2'b10 is a sync. It changes no flag and faults only when cmd_hyp_i is low.
- R10: A high bit of irq_ack_i clears that thread's flag at the next edge.
- R11: If a send sets a thread's flag in the same cycle as that thread's acknowledge, the flag ends up set.
- R12: Opcode 2'b11 completes as a no-op, with no fault, regardless of privilege.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Block can take a command |
| cmd_op_i | input | 2 | Opcode: 00 send, 01 clear, 10 sync, 11 none |
| cmd_operand_i | input | 64 | Message operand |
| cmd_thread_i | input | TIDX_W | Index of the issuing thread |
| cmd_hyp_i | input | 1 | Issuer is in hypervisor state |
| thread_id_i | input | NUM_THREADS*TAG_W | Static identifier of each thread; thread i occupies bits [i*TAG_W +: TAG_W] |
| irq_ack_i | input | NUM_THREADS | Per-thread interrupt-taken pulse |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Privilege fault, valid with done_o |
| irq_o | output | NUM_THREADS | Pending doorbell flag per thread |

## Verification
The hardest case to reach from the ports is a send and an acknowledge landing on the same thread in the same clock cycle. The flag update occurs at the edge that closes the done_o cycle. The bench therefore drives the acknowledge for an already-pending thread in exactly that cycle, and in the same step acknowledges a second, non-targeted thread. This shows that the set wins only where it applies. Duplicate thread identifiers are also configured, so that a single send must raise more than one flag.

// File: rtl/hvdb_pkg.sv
package hvdb_pkg;
    localparam int MSG_TYPE_LSB  = 27;
    localparam int MSG_TYPE_W    = 5;
    localparam int MSG_TYPE_HVDB = 5;
    localparam int TAG_W         = 20;
    localparam int OPERAND_W     = 64;

    typedef enum logic [1:0] {
        OP_SEND  = 2'b00,
        OP_CLEAR = 2'b01,
        OP_SYNC  = 2'b10,
        OP_NONE  = 2'b11
    } hvdb_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_EXEC = 1'b1
    } hvdb_state_e;
endpackage

// File: rtl/hvdb_decode.sv
module hvdb_decode
    import hvdb_pkg::*;
(
    input  logic [OPERAND_W-1:0] operand_i,
    output logic                 type_ok_o,
    output logic [TAG_W-1:0]     tag_o
);
    logic [MSG_TYPE_W-1:0] msg_type;
    logic                  unused_bits;

    assign msg_type    = operand_i[MSG_TYPE_LSB +: MSG_TYPE_W];
    assign type_ok_o   = (msg_type == MSG_TYPE_W'(MSG_TYPE_HVDB));
    assign tag_o       = operand_i[TAG_W-1:0];
    assign unused_bits = ^{operand_i[OPERAND_W-1:MSG_TYPE_LSB+MSG_TYPE_W],
                           operand_i[MSG_TYPE_LSB-1:TAG_W]};
endmodule

// File: rtl/hvdb_match.sv
module hvdb_match
    import hvdb_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [NUM_THREADS*TAG_W-1:0] ids_i,
    input  logic [TAG_W-1:0]             tag_i,
    output logic [NUM_THREADS-1:0]       hit_o
);
    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_cmp
        assign hit_o[g] = (ids_i[g*TAG_W +: TAG_W] == tag_i);
    end
endmodule

// File: rtl/hvdb_pending.sv
module hvdb_pending #(
    parameter int NUM_THREADS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] set_i,
    input  logic [NUM_THREADS-1:0] clr_i,
    input  logic [NUM_THREADS-1:0] ack_i,
    output logic [NUM_THREADS-1:0] pend_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_o <= '0;
        end else begin
            pend_o <= (pend_o & ~(clr_i | ack_i)) | set_i;
        end
    end

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
        AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            set_i[g] |=> pend_o[g]); // R11
        AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i[g] && !set_i[g]) |=> !pend_o[g]); // R10
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_i[g] && !clr_i[g] && !ack_i[g]) |=> (pend_o[g] == $past(pend_o[g]))); // R4
    end
endmodule

// File: rtl/hv_doorbell_dispatch.sv
module hv_doorbell_dispatch
    import hvdb_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    localparam int TIDX_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_valid_i,
    output logic                         cmd_ready_o,
    input  logic [1:0]                   cmd_op_i,
    input  logic [OPERAND_W-1:0]         cmd_operand_i,
    input  logic [TIDX_W-1:0]            cmd_thread_i,
    input  logic                         cmd_hyp_i,
    input  logic [NUM_THREADS*TAG_W-1:0] thread_id_i,
    input  logic [NUM_THREADS-1:0]       irq_ack_i,
    output logic                         done_o,
    output logic                         fault_o,
    output logic [NUM_THREADS-1:0]       irq_o
);
    hvdb_state_e            state_q, state_d;
    hvdb_op_e               op_q;
    logic [OPERAND_W-1:0]   operand_q;
    logic [TIDX_W-1:0]      thread_q;
    logic                   hyp_q;

    logic                   type_ok;
    logic [TAG_W-1:0]       tag;
    logic [NUM_THREADS-1:0] hit;
    logic [NUM_THREADS-1:0] set_vec, clr_vec;
    logic                   needs_priv, cmd_fault, may_act;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            op_q      <= OP_NONE;
            operand_q <= '0;
            thread_q  <= '0;
            hyp_q     <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && cmd_valid_i) begin
                op_q      <= hvdb_op_e'(cmd_op_i);
                operand_q <= cmd_operand_i;
                thread_q  <= cmd_thread_i;
                hyp_q     <= cmd_hyp_i;
            end
        end
    end

    hvdb_decode u_decode (
        .operand_i (operand_q),
        .type_ok_o (type_ok),
        .tag_o     (tag)
    );

    hvdb_match #(.NUM_THREADS(NUM_THREADS)) u_match (
        .ids_i (thread_id_i),
        .tag_i (tag),
        .hit_o (hit)
    );

    assign needs_priv = (op_q != OP_NONE);
    assign cmd_fault  = needs_priv && !hyp_q;
    assign may_act    = (state_q == ST_EXEC) && !cmd_fault && type_ok;

    always_comb begin
        state_d     = state_q;
        cmd_ready_o = 1'b0;
        done_o      = 1'b0;
        fault_o     = 1'b0;
        set_vec     = '0;
        clr_vec     = '0;
        unique case (state_q)
            ST_IDLE: begin
                cmd_ready_o = 1'b1;
                if (cmd_valid_i) state_d = ST_EXEC;   // ACCEPT
            end
            ST_EXEC: begin
                done_o  = 1'b1;
                fault_o = cmd_fault;
                if (may_act && op_q == OP_SEND)  set_vec = hit;
                if (may_act && op_q == OP_CLEAR) clr_vec[thread_q] = 1'b1;
                state_d = ST_IDLE;                     // RETIRE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    hvdb_pending #(.NUM_THREADS(NUM_THREADS)) u_pending (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (set_vec),
        .clr_i  (clr_vec),
        .ack_i  (irq_ack_i),
        .pend_o (irq_o)
    );

    AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_i && cmd_ready_o) |=> done_o); // R2
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_ready_o); // R2
    AST_FAULT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> done_o); // R8
    AST_FAULT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && fault_o && (irq_ack_i == '0)) |=> $stable(irq_o)); // R8
endmodule

// File: tb/test_hv_doorbell_dispatch.sv
`timescale 1ns/1ps
module test_hv_doorbell_dispatch;
    localparam int N = 4;
    localparam int TW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid_i = 1'b0;
    logic          cmd_ready_o;
    logic [1:0]    cmd_op_i = 2'b11;
    logic [63:0]   cmd_operand_i = '0;
    logic [1:0]    cmd_thread_i = '0;
    logic          cmd_hyp_i = 1'b0;
    logic [N*TW-1:0] thread_id_i;
    logic [N-1:0]  irq_ack_i = '0;
    logic          done_o, fault_o;
    logic [N-1:0]  irq_o;

    int checks = 0;
    int failures = 0;
    logic got_fault;

    assign thread_id_i = {20'hFFFFF, 20'h00020, 20'h00020, 20'h00010};

    always #10 clk = ~clk;

    hv_doorbell_dispatch #(.NUM_THREADS(N)) i_hv_doorbell_dispatch (
        .clk(clk), .rst_n(rst_n), .cmd_valid_i(cmd_valid_i), .cmd_ready_o(cmd_ready_o),
        .cmd_op_i(cmd_op_i), .cmd_operand_i(cmd_operand_i), .cmd_thread_i(cmd_thread_i),
        .cmd_hyp_i(cmd_hyp_i), .thread_id_i(thread_id_i), .irq_ack_i(irq_ack_i),
        .done_o(done_o), .fault_o(fault_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [4:0] typ, input logic bc, input logic [19:0] tag);
        return {32'h0, typ, bc, 6'h0, tag};
    endfunction

    task automatic do_cmd(input logic [1:0] op, input logic [63:0] opnd, input logic [1:0] thr,
                          input logic hyp, input logic [N-1:0] ack_mask);
        @(negedge clk);
        cmd_valid_i = 1'b1; cmd_op_i = op; cmd_operand_i = opnd;
        cmd_thread_i = thr; cmd_hyp_i = hyp;
        @(posedge clk);
        @(negedge clk);
        cmd_valid_i = 1'b0;
        irq_ack_i = ack_mask;
        check("R2 done pulse", {63'h0, done_o}, 64'h1);
        check("R2 ready low while busy", {63'h0, cmd_ready_o}, 64'h0);
        got_fault = fault_o;
        @(posedge clk);
        @(negedge clk);
        irq_ack_i = '0;
        check("R2 done ends", {63'h0, done_o}, 64'h0);
    endtask

    task automatic t_reset;
        check("R1 irq reset", {60'h0, irq_o}, 64'h0);
        check("R1 ready reset", {63'h0, cmd_ready_o}, 64'h1);
        check("R1 done reset", {63'h0, done_o}, 64'h0);
    endtask

    task automatic t_send;
        do_cmd(2'b00, mk(5'd5, 1'b0, 20'h00010), 2'd3, 1'b1, '0);
        check("R3 send fault", {63'h0, got_fault}, 64'h0);
        check("R3 send single", {60'h0, irq_o}, 64'h1);
        do_cmd(2'b00, mk(5'd5, 1'b0, 20'h00020), 2'd0, 1'b1, '0);
        check("R3 send duplicate ids", {60'h0, irq_o}, 64'h7);
    endtask

    task automatic t_reserved;
        do_cmd(2'b00, mk(5'd4, 1'b0, 20'hFFFFF), 2'd0, 1'b1, '0);
        check("R4 reserved fault", {63'h0, got_fault}, 64'h0);
        check("R4 reserved no-op", {60'h0, irq_o}, 64'h7);
        do_cmd(2'b00, mk(5'd6, 1'b0, 20'hFFFFF), 2'd0, 1'b1, '0);
        check("R4 reserved type6 no-op", {60'h0, irq_o}, 64'h7);
    endtask

    task automatic t_nomatch;
        do_cmd(2'b00, mk(5'd5, 1'b0, 20'h12345), 2'd0, 1'b1, '0);
        check("R5 nomatch fault", {63'h0, got_fault}, 64'h0);
        check("R5 nomatch no change", {60'h0, irq_o}, 64'h7);
    endtask

    task automatic t_bcast;
        do_cmd(2'b00, mk(5'd5, 1'b1, 20'hFFFFF) | 64'hDEAD_0000_03F0_0000, 2'd0, 1'b1, '0);
        check("R6 bcast fault", {63'h0, got_fault}, 64'h0);
        check("R6 bcast directed", {60'h0, irq_o}, 64'hF);
    endtask

    task automatic t_clear;
        do_cmd(2'b01, mk(5'd5, 1'b0, 20'h00010), 2'd1, 1'b1, '0);
        check("R7 clear fault", {63'h0, got_fault}, 64'h0);
        check("R7 clear own thread", {60'h0, irq_o}, 64'hD);
        do_cmd(2'b01, mk(5'd0, 1'b0, 20'h00010), 2'd0, 1'b1, '0);
        check("R7 reserved clear no-op", {60'h0, irq_o}, 64'hD);
    endtask

    task automatic t_priv;
        do_cmd(2'b00, mk(5'd5, 1'b0, 20'h00020), 2'd0, 1'b0, '0);
        check("R8 send fault", {63'h0, got_fault}, 64'h1);
        check("R8 send blocked", {60'h0, irq_o}, 64'hD);
        do_cmd(2'b01, mk(5'd5, 1'b0, 20'h0), 2'd0, 1'b0, '0);
        check("R8 clear fault", {63'h0, got_fault}, 64'h1);
        check("R8 clear blocked", {60'h0, irq_o}, 64'hD);
        check("R8 fault after done", {63'h0, fault_o}, 64'h0);
    endtask

    task automatic t_sync;
        do_cmd(2'b10, mk(5'd5, 1'b0, 20'h00020), 2'd1, 1'b1, '0);
        check("R9 sync priv fault", {63'h0, got_fault}, 64'h0);
        check("R9 sync no effect", {60'h0, irq_o}, 64'hD);
        do_cmd(2'b10, mk(5'd5, 1'b0, 20'h00020), 2'd1, 1'b0, '0);
        check("R9 sync unpriv fault", {63'h0, got_fault}, 64'h1);
    endtask

    task automatic t_noneop;
        do_cmd(2'b11, mk(5'd5, 1'b0, 20'h00020), 2'd1, 1'b0, '0);
        check("R12 none fault", {63'h0, got_fault}, 64'h0);
        check("R12 none no effect", {60'h0, irq_o}, 64'hD);
    endtask

    task automatic t_ack;
        @(negedge clk); irq_ack_i = 4'b1000;
        @(posedge clk);
        @(negedge clk); irq_ack_i = '0;
        check("R10 ack clears", {60'h0, irq_o}, 64'h5);
    endtask

    task automatic t_race;
        do_cmd(2'b00, mk(5'd5, 1'b0, 20'h00010), 2'd0, 1'b1, 4'b0101);
        check("R11 set beats ack", {60'h0, irq_o}, 64'h1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_send();
        t_reserved();
        t_nomatch();
        t_bcast();
        t_clear();
        t_priv();
        t_sync();
        t_noneop();
        t_ack();
        t_race();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule